// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register Decoder

This block sits at the host side of a two-channel disk controller. Every host byte access arrives as an address with a read or write strobe. The block resolves that address against five relocatable windows:

- a command window of eight bytes for each channel;
- a one-byte control window for each channel;
- a shared eight-byte DMA window, whose lower half belongs to channel 0 and whose upper half belongs to channel 1.

It reports the decoded channel, a register code and a hit or bus-error flag. Some offsets name different registers depending on the access direction, and the register code reflects this.

The block keeps the plain per-channel byte registers itself and returns their contents on reads. These are sector count, sector number, cylinder low and high, drive/head, DMA command and DMA status. For the registers owned by the command sequencer (data, command, status, alternate status and device control) it raises a one-cycle strobe, and the read data it returns for them is zero.

Window base addresses reset to legacy defaults and can be moved through a small configuration port. When windows overlap, the lowest-numbered window wins.

Top module: `ioreg_decoder`

## Requirements
- R1: While reset is asserted and after its release, all decode outputs and strobes are 0, and every stored register reads 0.
- R2: A read at offset k (0..7) of channel c's command window returns chan=c, code=k (0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status).
- R3: A write to a command window uses the same codes, except offset 1 gives code 8 (feature) and offset 7 gives code 9 (command).
- R4: A read of channel c's control byte gives code 10 (alternate status) with the altstat strobe; a write gives code 11 (device control) with the control strobe.
- R5: In the DMA window, offset bit 2 selects the channel and bits 1:0 select code 12 (DMA command), 13 (unused), 14 (DMA status) or 15 (unused).
- R6: An access that matches no window sets bus_err and clears dec_hit; dec_hit and bus_err are never set together.
- R7: Codes 2..6, 12 and 14 are byte storage per channel: a write is returned by later reads of the same channel and code, and the other channel is left untouched.
- R8: Codes 13 and 15 read as 0, and writes to them change no stored register.
- R9: Window bases are selected by cfg_sel (0 command ch0, 1 command ch1, 2 control ch0, 3 control ch1, 4 DMA) and load on cfg_we; a cfg_sel above 4 changes nothing.
- R10: When windows overlap, the lowest-numbered matching window decodes the access.
- R11: stb_data fires on code 0 in either direction, stb_status on a read of code 7 and stb_cmd on a write of code 9. At most one strobe is high at a time, and rdata is 0 for every code that is not stored.
- R12: Each access is answered in the cycle after the edge that samples it, for that one cycle only; with no access, dec_hit and bus_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load a window base |
| cfg_sel | input | 3 | Window selected for loading |
| cfg_base | input | AW | New base address |
| acc_addr | input | AW | Host access address |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe (wins if both are high) |
| acc_wdata | input | 8 | Write data |
| dec_chan | output | 1 | Decoded channel |
| dec_reg | output | 5 | Decoded register code |
| dec_hit | output | 1 | Access matched a window |
| bus_err | output | 1 | Access matched no window |
| rdata | output | 8 | Read data for stored registers |
| stb_data | output | 1 | Data register access |
| stb_cmd | output | 1 | Command register write |
| stb_status | output | 1 | Status register read |
| stb_altstat | output | 1 | Alternate status read |
| stb_ctrl | output | 1 | Device control write |

## Verification
Every decode output, strobe and read byte is registered, so each result appears one cycle after the rising edge that samples the access. The bench drives an access at a falling edge and removes it at the next falling edge, which is where it samples. A stored write is committed on that same rising edge, so a read issued in the following cycle already returns the new value, and the bench checks read-back in that order. An extra idle cycle is then sampled to confirm that the response lasts only one cycle.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
    localparam int NCH    = 2;
    localparam int NWIN   = 5;
    localparam int NSTORE = 7;

    typedef enum logic [4:0] {
        RG_DATA  = 5'd0,  RG_ERR   = 5'd1,  RG_SCNT  = 5'd2,  RG_SNUM  = 5'd3,
        RG_CYLL  = 5'd4,  RG_CYLH  = 5'd5,  RG_DRVH  = 5'd6,  RG_STAT  = 5'd7,
        RG_FEAT  = 5'd8,  RG_CMD   = 5'd9,  RG_ALT   = 5'd10, RG_DCTL  = 5'd11,
        RG_DCMD  = 5'd12, RG_DPAD1 = 5'd13, RG_DSTAT = 5'd14, RG_DPAD3 = 5'd15
    } reg_e;

    function automatic int win_size(int w);
        if (w < 2) return 8;
        if (w < 4) return 1;
        return 8;
    endfunction
endpackage

// File: rtl/ioreg_win_match.sv
module ioreg_win_match #(
    parameter int AW   = 16,
    parameter int SIZE = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [2:0]    off
);
    logic [AW-1:0] diff;

    always_comb begin
        diff = addr - base;
        hit  = (addr >= base) && (diff < AW'(SIZE));
        off  = (SIZE > 1) ? diff[2:0] : 3'd0;
    end
endmodule

// File: rtl/ioreg_map.sv
module ioreg_map
    import ioreg_pkg::*;
(
    input  logic [2:0] win,
    input  logic [2:0] off,
    input  logic       is_wr,
    output logic       chan,
    output reg_e       code
);
    always_comb begin
        chan = win[0];
        code = RG_DATA;
        case (win)
            3'd0, 3'd1: begin
                code = reg_e'({2'b00, off});
                if (is_wr && off == 3'd1) code = RG_FEAT;
                if (is_wr && off == 3'd7) code = RG_CMD;
            end
            3'd2, 3'd3: code = is_wr ? RG_DCTL : RG_ALT;
            default: begin
                chan = off[2];
                code = reg_e'(5'd12 + {3'b000, off[1:0]});
            end
        endcase
    end
endmodule

// File: rtl/ioreg_store.sv
module ioreg_store
    import ioreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       chan,
    input  reg_e       code,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    typedef logic [NCH-1:0][NSTORE-1:0][7:0] bank_t;

    bank_t store_d, store_q;
    logic  valid;
    logic [2:0] slot;

    always_comb begin
        valid = 1'b1;
        slot  = 3'd0;
        case (code)
            RG_SCNT:  slot = 3'd0;
            RG_SNUM:  slot = 3'd1;
            RG_CYLL:  slot = 3'd2;
            RG_CYLH:  slot = 3'd3;
            RG_DRVH:  slot = 3'd4;
            RG_DCMD:  slot = 3'd5;
            RG_DSTAT: slot = 3'd6;
            default:  valid = 1'b0;
        endcase
    end

    always_comb begin
        store_d = store_q;
        if (we && valid) store_d[chan][slot] = wdata;
        rdata = valid ? store_q[chan][slot] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    // R8
    pad_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (code == RG_DPAD1 || code == RG_DPAD3)) |=> $stable(store_q));
endmodule

// File: rtl/ioreg_decoder.sv
module ioreg_decoder
    import ioreg_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BASE_CMD0 = 'h01F0,
    parameter int BASE_CMD1 = 'h0170,
    parameter int BASE_CTL0 = 'h03F6,
    parameter int BASE_CTL1 = 'h0376,
    parameter int BASE_DMA  = 'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [7:0]    acc_wdata,
    output logic          dec_chan,
    output logic [4:0]    dec_reg,
    output logic          dec_hit,
    output logic          bus_err,
    output logic [7:0]    rdata,
    output logic          stb_data,
    output logic          stb_cmd,
    output logic          stb_status,
    output logic          stb_altstat,
    output logic          stb_ctrl
);
    typedef struct packed {
        logic [NWIN-1:0][AW-1:0] base;
        logic                    chan;
        reg_e                    code;
        logic                    hit;
        logic                    berr;
        logic [7:0]              rdata;
        logic                    s_data;
        logic                    s_cmd;
        logic                    s_stat;
        logic                    s_alt;
        logic                    s_ctl;
    } st_t;

    st_t st_d, st_q;
    st_t st_rst;

    logic [NWIN-1:0]      win_hit;
    logic [NWIN-1:0][2:0] win_off;
    logic [2:0]           sel_idx;
    logic [2:0]           off_sel;
    logic                 any_hit;
    logic                 acc;
    logic                 map_chan;
    reg_e                 map_code;
    logic [7:0]           rf_rdata;

    assign acc = acc_rd | acc_wr;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ioreg_win_match #(.AW(AW), .SIZE(win_size(w))) u_match (
            .base (st_q.base[w]),
            .addr (acc_addr),
            .hit  (win_hit[w]),
            .off  (win_off[w])
        );
    end

    always_comb begin
        sel_idx = 3'd0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (win_hit[i]) sel_idx = 3'(i);
        end
        any_hit = |win_hit;
        off_sel = win_off[sel_idx];
    end

    ioreg_map u_map (
        .win   (sel_idx),
        .off   (off_sel),
        .is_wr (acc_wr),
        .chan  (map_chan),
        .code  (map_code)
    );

    ioreg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_wr && any_hit),
        .chan  (map_chan),
        .code  (map_code),
        .wdata (acc_wdata),
        .rdata (rf_rdata)
    );

    always_comb begin
        st_rst         = '0;
        st_rst.base[0] = AW'(BASE_CMD0);
        st_rst.base[1] = AW'(BASE_CMD1);
        st_rst.base[2] = AW'(BASE_CTL0);
        st_rst.base[3] = AW'(BASE_CTL1);
        st_rst.base[4] = AW'(BASE_DMA);
    end

    always_comb begin
        st_d        = st_q;
        st_d.chan   = 1'b0;
        st_d.code   = RG_DATA;
        st_d.hit    = 1'b0;
        st_d.berr   = 1'b0;
        st_d.rdata  = 8'h00;
        st_d.s_data = 1'b0;
        st_d.s_cmd  = 1'b0;
        st_d.s_stat = 1'b0;
        st_d.s_alt  = 1'b0;
        st_d.s_ctl  = 1'b0;
        if (cfg_we && (int'(cfg_sel) < NWIN)) st_d.base[cfg_sel] = cfg_base;
        if (acc) begin
            if (any_hit) begin
                st_d.hit    = 1'b1;
                st_d.chan   = map_chan;
                st_d.code   = map_code;
                st_d.rdata  = acc_wr ? 8'h00 : rf_rdata;
                st_d.s_data = (map_code == RG_DATA);
                st_d.s_cmd  = (map_code == RG_CMD);
                st_d.s_stat = (map_code == RG_STAT);
                st_d.s_alt  = (map_code == RG_ALT);
                st_d.s_ctl  = (map_code == RG_DCTL);
            end else begin
                st_d.berr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign dec_chan    = st_q.chan;
    assign dec_reg     = st_q.code;
    assign dec_hit     = st_q.hit;
    assign bus_err     = st_q.berr;
    assign rdata       = st_q.rdata;
    assign stb_data    = st_q.s_data;
    assign stb_cmd     = st_q.s_cmd;
    assign stb_status  = st_q.s_stat;
    assign stb_altstat = st_q.s_alt;
    assign stb_ctrl    = st_q.s_ctl;

    // R6
    hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_hit && bus_err));
    // R12
    resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (dec_hit || bus_err));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!dec_hit && !bus_err));
    // R11
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_data, stb_cmd, stb_status, stb_altstat, stb_ctrl}));
    // R3
    cmd_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_cmd |-> $past(acc_wr));
    // R2
    status_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_status |-> !$past(acc_wr));
endmodule

// File: tb/sim_ioreg_decoder.sv
`timescale 1ns/1ps
module sim_ioreg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] acc_addr = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic        dec_chan, dec_hit, bus_err;
    logic [4:0]  dec_reg;
    logic [7:0]  rdata;
    logic        stb_data, stb_cmd, stb_status, stb_altstat, stb_ctrl;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [2][16];
    logic [15:0] wbase [5];

    always #5 clk = ~clk;

    ioreg_decoder u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit stored(input int code);
        return code inside {2, 3, 4, 5, 6, 12, 14};
    endfunction

    function automatic int exp_code(input int win, input int off, input bit wr);
        if (win < 2) begin
            if (wr && off == 1) return 8;
            if (wr && off == 7) return 9;
            return off;
        end
        if (win < 4) return wr ? 11 : 10;
        return 12 + (off % 4);
    endfunction

    function automatic int exp_stb(input int code, input bit wr);
        if (code == 0) return 5'b10000;
        if (code == 9 && wr) return 5'b01000;
        if (code == 7 && !wr) return 5'b00100;
        if (code == 10) return 5'b00010;
        if (code == 11) return 5'b00001;
        return 0;
    endfunction

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr = a; acc_wr = wr; acc_rd = !wr; acc_wdata = d;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic cfg(input int idx, input logic [15:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_base = b;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 5) wbase[idx] = b;
    endtask

    task automatic hit_chk(input string req, input bit wr, input int win, input int off, input logic [7:0] d);
        int code, ch, st;
        access(wr, wbase[win] + 16'(off), d);
        code = exp_code(win, off, wr);
        ch = (win < 4) ? (win % 2) : (off / 4);
        st = exp_stb(code, wr);
        chk(req, "hit", int'(dec_hit), 1);
        chk(req, "bus_err", int'(bus_err), 0);
        chk(req, "chan", int'(dec_chan), ch);
        chk(req, "code", int'(dec_reg), code);
        chk("R11", "strobes", int'({stb_data, stb_cmd, stb_status, stb_altstat, stb_ctrl}), st);
        if (!wr) chk(stored(code) ? "R7" : "R8", "rdata", int'(rdata), stored(code) ? int'(model[ch][code]) : 0);
        if (wr && stored(code)) model[ch][code] = d;
    endtask

    task automatic miss_chk(input string req, input logic [15:0] a);
        access(1'b0, a, 8'h00);
        chk(req, "bus_err", int'(bus_err), 1);
        chk(req, "hit", int'(dec_hit), 0);
        chk(req, "strobes", int'({stb_data, stb_cmd, stb_status, stb_altstat, stb_ctrl}), 0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        foreach (model[c, r]) model[c][r] = 8'h00;
        wbase[0] = 16'h01F0; wbase[1] = 16'h0170; wbase[2] = 16'h03F6;
        wbase[3] = 16'h0376; wbase[4] = 16'h0200;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "hit", int'(dec_hit), 0);
        chk("R1", "bus_err", int'(bus_err), 0);
        chk("R1", "strobes", int'({stb_data, stb_cmd, stb_status, stb_altstat, stb_ctrl}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rdata", int'(rdata), 0);

        // R2 / R1: read sweep before any write (stored registers read 0)
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 8; o++) hit_chk("R2", 1'b0, c, o, 8'h00);
        // R3 / R7: write sweep then read back
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 8; o++) hit_chk("R3", 1'b1, c, o, 8'(8'h31 + c * 16 + o * 3));
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 8; o++) hit_chk("R7", 1'b0, c, o, 8'h00);
        // R4: control bytes
        for (int c = 2; c < 4; c++) begin
            hit_chk("R4", 1'b0, c, 0, 8'h00);
            hit_chk("R4", 1'b1, c, 0, 8'h02);
        end
        // R5 / R8: DMA window split
        for (int o = 0; o < 8; o++) hit_chk("R5", 1'b1, 4, o, 8'(8'hA0 + o * 5));
        for (int o = 0; o < 8; o++) hit_chk("R5", 1'b0, 4, o, 8'h00);
        // R7: channel 0 command registers unaffected by channel 1 writes
        hit_chk("R7", 1'b1, 1, 2, 8'h5A);
        hit_chk("R7", 1'b0, 0, 2, 8'h00);
        hit_chk("R7", 1'b0, 1, 2, 8'h00);

        // R6: unmatched addresses
        miss_chk("R6", 16'h0000);
        miss_chk("R6", 16'h01EF);
        miss_chk("R6", 16'h01F8);
        miss_chk("R6", 16'h03F7);
        miss_chk("R6", 16'h0208);
        miss_chk("R6", 16'hFFFF);

        // R12: response lasts one cycle
        access(1'b0, 16'h01F2, 8'h00);
        chk("R12", "hit", int'(dec_hit), 1);
        @(negedge clk);
        chk("R12", "hit idle", int'(dec_hit), 0);
        chk("R12", "bus_err idle", int'(bus_err), 0);

        // R9: relocate channel 1 command window; R10: overlap priority
        cfg(1, 16'h01F4);
        miss_chk("R9", 16'h0170);
        access(1'b0, 16'h01F5, 8'h00);
        chk("R10", "chan", int'(dec_chan), 0);
        chk("R10", "code", int'(dec_reg), 5);
        chk("R10", "rdata", int'(rdata), int'(model[0][5]));
        hit_chk("R9", 1'b0, 1, 6, 8'h00);
        // R9: out-of-range select ignored
        cfg(5, 16'h0000);
        miss_chk("R9", 16'h0000);
        cfg(6, 16'h0100);
        miss_chk("R9", 16'h0100);
        hit_chk("R9", 1'b0, 4, 4, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule